// File: doc/BRIEF.md
# Transmit Request Arbitration Register

This block holds one transmit request bit for each of sixteen message buffers in a frame-based bus controller. Software sets request bits through a 16-bit register port; each set bit stays pending until the transmit engine reports that the frame has gone out, or until a per-buffer cancel pulse removes it. A per-buffer gate can hold a pending buffer back until a remote request for that buffer has been received.

Every cycle in which the transmit engine is idle, the block picks the lowest-numbered eligible buffer. It issues a one-cycle start pulse to the engine carrying the buffer index and a frame-type bit taken from a companion per-buffer type register (0 for a data frame, 1 for a remote frame). It then stays busy until the engine returns a done pulse. Reads of the request register show the pending bits. A read that belongs to a read-modify-write access returns zeros, so a write-back never re-arms a buffer.

Top module: `tx_req_arb`

## Requirements
- R1: After reset, the request bits and the frame-type bits are all 0, tx_start_o is 0 and tx_busy_o is 0.
- R2: A write with reg_sel_i=0 sets every request bit whose data bit is 1. Data bits that are 0 leave their request bits unchanged.
- R3: A pending buffer whose wait flag (wait_rmt_i bit) is 0 is eligible. With the engine idle, tx_start_o is 1 in the cycle after the write that set the request.
- R4: A pending buffer whose wait flag is 1 is not started until its received flag (rmt_rcvd_i bit) is 1. If the received flag is already 1 at the time of the write, the buffer is started as under R3.
- R5: When several buffers are eligible, tx_idx_o at the start pulse is the lowest-numbered eligible buffer. The choice is made again in each idle cycle.
- R6: A request bit reads 1 while its buffer is waiting or transmitting. It reads 0 in the cycle after tx_done_i is seen while busy.
- R7: If tx_done_i and a software set of the active buffer's request bit fall in the same cycle, the bit ends at 0.
- R8: With reg_sel_i=0 and reg_rmw_i=1, reg_rdata_o is 0. With reg_rmw_i=0, it is the pending bits.
- R9: A write with reg_sel_i=1 loads the frame-type register, and reads with reg_sel_i=1 return it. At the start pulse, tx_remote_o equals the type bit of the started buffer.
- R10: A cancel_i pulse clears the request bit of a buffer that has not been started. A cancel aimed at the buffer in transmission is ignored.
- R11: tx_start_o lasts exactly one cycle. No further start is issued while tx_busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 1 | Register select: 0 request bits, 1 frame-type bits |
| reg_we_i | input | 1 | Register write enable |
| reg_rmw_i | input | 1 | Marks the current read as part of a read-modify-write |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data |
| wait_rmt_i | input | 16 | Per-buffer wait-for-remote-request flags |
| rmt_rcvd_i | input | 16 | Per-buffer remote-request-received flags |
| cancel_i | input | 16 | Per-buffer cancel pulses |
| tx_start_o | output | 1 | One-cycle start pulse to the transmit engine |
| tx_idx_o | output | 4 | Index of the started buffer |
| tx_remote_o | output | 1 | Frame type of the started buffer: 1 remote, 0 data |
| tx_busy_o | output | 1 | Engine handshake in progress |
| tx_done_i | input | 1 | Transmission of the active buffer finished |

## Verification
A pending bit that is lost or stuck appears at once on reg_rdata_o. Within one cycle it also appears as a missing or extra start pulse. A wrong priority or a wrong gate decision shows up on tx_idx_o at the first start after the faulty state arises. Because every done is followed by a new selection, one bad request corrupts the whole order of later starts. An active index that is not held correctly shows up one cycle after done, as a request bit that reads back as still set.

// File: rtl/tx_req_pkg.sv
package tx_req_pkg;
  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_BUSY = 1'b1
  } eng_state_e;
endpackage

// File: rtl/tx_req_pend.sv
module tx_req_pend #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  // clear has priority over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q | set_i) & ~clr_i;
  end

  assign pend_o = pend_q;

  assert_clear_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((pend_o & $past(clr_i)) == '0));
endmodule

// File: rtl/tx_req_gate.sv
module tx_req_gate #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] wait_i,
  input  logic [N-1:0] rcvd_i,
  input  logic [N-1:0] block_i,
  output logic [N-1:0] elig_o
);
  logic [N-1:0] seen_q;

  // remember a remote request seen while pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else         seen_q <= pend_i & (seen_q | rcvd_i);
  end

  for (genvar g = 0; g < N; g++) begin : g_gate
    assign elig_o[g] = pend_i[g] & ~block_i[g] & (~wait_i[g] | rcvd_i[g] | seen_q[g]);
  end
endmodule

// File: rtl/tx_req_pick.sv
module tx_req_pick #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (any_o) begin
      assert_lowest_first_R5: assert (req_i[idx_o] && ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/tx_req_arb.sv
module tx_req_arb
  import tx_req_pkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int IDX_W   = $clog2(NUM_BUF)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_sel_i,
  input  logic               reg_we_i,
  input  logic               reg_rmw_i,
  input  logic [NUM_BUF-1:0] reg_wdata_i,
  output logic [NUM_BUF-1:0] reg_rdata_o,
  input  logic [NUM_BUF-1:0] wait_rmt_i,
  input  logic [NUM_BUF-1:0] rmt_rcvd_i,
  input  logic [NUM_BUF-1:0] cancel_i,
  output logic               tx_start_o,
  output logic [IDX_W-1:0]   tx_idx_o,
  output logic               tx_remote_o,
  output logic               tx_busy_o,
  input  logic               tx_done_i
);
  localparam logic [NUM_BUF-1:0] ONE = NUM_BUF'(1);

  eng_state_e         state_q;
  logic [IDX_W-1:0]   act_q;
  logic               start_q, remote_q;
  logic [NUM_BUF-1:0] ftype_q;
  logic [NUM_BUF-1:0] pend, elig, set_vec, clr_vec, act_mask;
  logic               any;
  logic [IDX_W-1:0]   pick_idx;
  logic               busy;

  assign busy     = (state_q == ENG_BUSY);
  assign act_mask = busy ? (ONE << act_q) : '0;
  assign set_vec  = (reg_we_i && !reg_sel_i) ? reg_wdata_i : '0;
  // done clears the active bit; cancel never touches the active bit
  assign clr_vec  = (tx_done_i ? act_mask : '0) | (cancel_i & ~act_mask);

  tx_req_pend #(.N(NUM_BUF)) u_pend (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .set_i (set_vec), .clr_i(clr_vec), .pend_o(pend)
  );

  tx_req_gate #(.N(NUM_BUF)) u_gate (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .pend_i(pend), .wait_i(wait_rmt_i), .rcvd_i(rmt_rcvd_i),
    .block_i(cancel_i), .elig_o(elig)
  );

  tx_req_pick #(.N(NUM_BUF), .IDX_W(IDX_W)) u_pick (
    .req_i(elig), .any_o(any), .idx_o(pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ftype_q <= '0;
    else if (reg_we_i && reg_sel_i) ftype_q <= reg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ENG_IDLE;
      act_q    <= '0;
      start_q  <= 1'b0;
      remote_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        ENG_IDLE: if (any) begin
          state_q  <= ENG_BUSY;
          act_q    <= pick_idx;
          start_q  <= 1'b1;
          remote_q <= ftype_q[pick_idx];
        end
        ENG_BUSY: if (tx_done_i) state_q <= ENG_IDLE;
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assign tx_start_o  = start_q;
  assign tx_idx_o    = act_q;
  assign tx_remote_o = remote_q;
  assign tx_busy_o   = busy;

  always_comb begin
    if (reg_sel_i)      reg_rdata_o = ftype_q;
    else if (reg_rmw_i) reg_rdata_o = '0;
    else                reg_rdata_o = pend;
  end

  assert_start_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o);
  assert_no_start_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_o |=> !tx_start_o);
  assert_start_pending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> (tx_busy_o && pend[tx_idx_o]));
  assert_done_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_busy_o && tx_done_i) |=> (!tx_busy_o && !pend[$past(tx_idx_o)]));
  assert_cancel_active_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_busy_o && !tx_done_i && cancel_i[tx_idx_o]) |=> pend[$past(tx_idx_o)]);
endmodule

// File: tb/tx_req_arb_bench.sv
module tx_req_arb_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_sel_i = 1'b0, reg_we_i = 1'b0, reg_rmw_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic [15:0] wait_rmt_i = '0, rmt_rcvd_i = '0, cancel_i = '0;
  logic        tx_start_o, tx_remote_o, tx_busy_o;
  logic [3:0]  tx_idx_o;
  logic        tx_done_i = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #4 clk_i = ~clk_i;

  tx_req_arb u_tx_req_arb (
    .clk_i, .rst_ni, .reg_sel_i, .reg_we_i, .reg_rmw_i, .reg_wdata_i, .reg_rdata_o,
    .wait_rmt_i, .rmt_rcvd_i, .cancel_i,
    .tx_start_o, .tx_idx_o, .tx_remote_o, .tx_busy_o, .tx_done_i
  );

  task automatic tick();
    @(negedge clk_i); #1;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [15:0] d);
    reg_sel_i = sel; reg_we_i = 1'b1; reg_wdata_i = d;
    tick();
    reg_we_i = 1'b0; reg_sel_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd_req(string req, logic [15:0] exp);
    reg_sel_i = 1'b0; #1;
    chk(req, "request read", int'(reg_rdata_o), int'(exp));
  endtask

  task automatic done_pulse();
    tx_done_i = 1'b1; tick(); tx_done_i = 1'b0;
  endtask

  task automatic expect_start(string req, int idx, int rem);
    chk(req, "start", int'(tx_start_o), 1);
    chk(req, "index", int'(tx_idx_o), idx);
    chk(req, "remote", int'(tx_remote_o), rem);
  endtask

  task automatic t_reset();
    rd_req("R1", 16'h0000);
    reg_sel_i = 1'b1; #1;
    chk("R1", "type read", int'(reg_rdata_o), 0);
    reg_sel_i = 1'b0;
    chk("R1", "start", int'(tx_start_o), 0);
    chk("R1", "busy", int'(tx_busy_o), 0);
  endtask

  task automatic t_basic();
    wr(1'b0, 16'h0000);
    rd_req("R2", 16'h0000);
    tick();
    chk("R2", "no start after zero write", int'(tx_start_o), 0);
    wr(1'b0, 16'h0010);
    rd_req("R2", 16'h0010);
    tick();
    expect_start("R3", 4, 0);
    chk("R3", "busy", int'(tx_busy_o), 1);
    tick();
    chk("R11", "start one cycle", int'(tx_start_o), 0);
    wr(1'b0, 16'h0000);
    rd_req("R6", 16'h0010);
    done_pulse();
    chk("R6", "busy after done", int'(tx_busy_o), 0);
    rd_req("R6", 16'h0000);
  endtask

  task automatic t_priority();
    wr(1'b1, 16'h0400);
    reg_sel_i = 1'b1; #1;
    chk("R9", "type readback", int'(reg_rdata_o), 16'h0400);
    reg_sel_i = 1'b0;
    wr(1'b0, 16'h8421);
    tick();
    expect_start("R5", 0, 0);
    done_pulse();
    tick();
    expect_start("R5", 5, 0);
    wr(1'b0, 16'h0002);
    chk("R11", "no start while busy", int'(tx_start_o), 0);
    tick();
    chk("R11", "no start while busy", int'(tx_start_o), 0);
    done_pulse();
    tick();
    expect_start("R5", 1, 0);
    done_pulse();
    tick();
    expect_start("R9", 10, 1);
    done_pulse();
    tick();
    expect_start("R5", 15, 0);
    done_pulse();
    rd_req("R6", 16'h0000);
  endtask

  task automatic t_wait();
    wait_rmt_i = 16'h0048;
    wr(1'b0, 16'h0008);
    repeat (3) begin
      tick();
      chk("R4", "held until remote request", int'(tx_start_o), 0);
    end
    rd_req("R4", 16'h0008);
    rmt_rcvd_i[3] = 1'b1;
    tick();
    expect_start("R4", 3, 0);
    rmt_rcvd_i[3] = 1'b0;
    done_pulse();
    rmt_rcvd_i[6] = 1'b1;
    wr(1'b0, 16'h0040);
    tick();
    expect_start("R4", 6, 0);
    done_pulse();
    rmt_rcvd_i = '0;
    wait_rmt_i = '0;
  endtask

  task automatic t_clear_wins();
    wr(1'b0, 16'h0004);
    tick();
    expect_start("R7", 2, 0);
    tx_done_i = 1'b1;
    wr(1'b0, 16'h0004);
    tx_done_i = 1'b0;
    rd_req("R7", 16'h0000);
    tick();
    chk("R7", "no restart", int'(tx_start_o), 0);
  endtask

  task automatic t_rmw_cancel();
    wait_rmt_i = 16'h0101;
    wr(1'b0, 16'h0101);
    reg_rmw_i = 1'b1;
    rd_req("R8", 16'h0000);
    reg_rmw_i = 1'b0;
    rd_req("R8", 16'h0101);
    cancel_i[8] = 1'b1; tick(); cancel_i = '0;
    rd_req("R10", 16'h0001);
    rmt_rcvd_i[0] = 1'b1;
    tick();
    expect_start("R10", 0, 0);
    rmt_rcvd_i = '0;
    cancel_i[0] = 1'b1; tick(); cancel_i = '0;
    rd_req("R10", 16'h0001);
    chk("R10", "still busy", int'(tx_busy_o), 1);
    done_pulse();
    rd_req("R10", 16'h0000);
    wait_rmt_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_priority();
    t_wait();
    t_clear_wins();
    t_rmw_cancel();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule